// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Command Engine

This block is the protocol front end of a small serial memory reached over a two-wire bus. It watches the already synchronized clock and data lines, finds bus start and stop conditions, decodes the select byte against two type codes and three strap pins, and then runs the write and read transfers. A single bus address gives access to a 256-byte data memory and to a protection register. Read data comes from an external array through a combinational address and data path. Written bytes go out as load strobes to a page buffer. A commit pulse tells the write sequencer when a correctly ended write may be programmed.

An 8-bit address pointer persists between transfers. It serves current-address reads without an address phase, steps through sequential reads with wrap at the top of the memory, and steps only its low four bits during page writes. While the write sequencer reports busy, the engine ignores the bus. A master can therefore poll for completion by repeating the select byte until it is acknowledged.

Top module: `eeprom_cmd_engine`

## Requirements
- R1: After reset the engine releases the data line (sda_pull_o low), issues no load strobe or commit, and the address pointer (mem_addr_o) is 00h.
- R2: The select byte is taken MSB first. It is acknowledged (sda_pull_o high in the 9th clock slot) only when bits 7..4 are 1010 (memory) or 0110 (protection register) and bits 3..1 equal ce_i[2:0]. Bit 0 is read (1) or write (0). Any other byte is not acknowledged, and the engine ignores the bus until the next START.
- R3: In a memory write, the byte after the select is an address that loads the pointer. Each later data byte received while wr_allow_i is high is acknowledged and produces one ld_strobe_o, with ld_data_o equal to the byte and mem_addr_o equal to the pointer. The pointer's low 4 bits then step, wrapping inside a 16-byte page while bits 7..4 stay put. A data byte received while wr_allow_i is low is not acknowledged, gives no strobe and leaves the pointer unchanged.
- R4: commit_o pulses for one cycle when a STOP arrives directly after the 9th slot of a write data byte, provided at least one data byte was accepted. A STOP that arrives part way through a byte, or after only select or address bytes, gives no commit.
- R5: A random read is a write select plus an address byte, then a repeated START and a read select. It returns the byte at that address MSB first. sda_pull_o is high for a 0 bit and low for a 1 bit.
- R6: Every byte read from the memory advances the pointer by one, so a current-address read (read select with no address phase) returns the byte after the last one transferred.
- R7: In a read, a master ACK (data low in the 9th slot) causes the next byte to be sent. The pointer wraps from FFh to 00h.
- R8: A master NACK in the 9th slot of a read releases the bus. No further byte is acknowledged or driven until a new START.
- R9: While busy_i is high the engine does not drive the data line and acknowledges no select byte.
- R10: A START seen in any state abandons the current transfer without strobe or commit and starts reception of a new select byte.
- R11: For the protection type code, tgt_prot_o is high. Address and data bytes are acknowledged (data only while wr_allow_i is high) but give no ld_strobe_o and leave the pointer unchanged. A valid STOP gives commit_o with tgt_prot_o high. Reads of this target return FFh.
- R12: sda_pull_o is only asserted while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized bus clock |
| sda_i | input | 1 | Synchronized bus data |
| ce_i | input | 3 | Strap pins compared with select bits 3..1 |
| wr_allow_i | input | 1 | Protection arbiter permits the current data byte |
| busy_i | input | 1 | Write sequencer is programming |
| mem_rdata_i | input | 8 | Array read data for mem_addr_o |
| sda_pull_o | output | 1 | Pull the data line low (open drain) |
| mem_addr_o | output | 8 | Address pointer, used for reads and strobes |
| mem_rd_o | output | 1 | One-cycle pulse when a read byte is fetched |
| ld_strobe_o | output | 1 | One-cycle page buffer load strobe |
| ld_data_o | output | 8 | Byte to load into the page buffer |
| tgt_prot_o | output | 1 | Current transfer targets the protection register |
| commit_o | output | 1 | One-cycle request to start programming |

## Verification
The assertions assume that the master moves SDA only while SCL is low, except when it makes START and STOP. They also assume that SCL and SDA never change in the same clock cycle and that every level holds for several engine clocks. The bench master drives each line change on its own and holds it for four engine clocks, so edge detection always sees clean, single changes. busy_i and wr_allow_i are changed only between transfers, while the bus is idle, so the assertions that tie them to the data line see stable inputs.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W = 8;
    localparam int CE_W   = 3;
    localparam int TYPE_W = 4;

    localparam logic [TYPE_W-1:0] TYPE_MEM  = 4'b1010;
    localparam logic [TYPE_W-1:0] TYPE_PROT = 4'b0110;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL,
        ST_SEL_ACK,
        ST_ADR,
        ST_ADR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } eng_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } line_ev_t;

    typedef struct packed {
        logic load;
        logic step_seq;
        logic step_page;
    } ptr_cmd_t;

    // returns {hit, protection_target}
    function automatic logic [1:0] sel_decode(input logic [BYTE_W-1:0] sel,
                                              input logic [CE_W-1:0]   ce);
        logic ce_ok;
        logic is_mem;
        logic is_prot;
        ce_ok   = (sel[CE_W:1] == ce);
        is_mem  = (sel[BYTE_W-1 -: TYPE_W] == TYPE_MEM);
        is_prot = (sel[BYTE_W-1 -: TYPE_W] == TYPE_PROT);
        return {ce_ok & (is_mem | is_prot), is_prot};
    endfunction

endpackage

// File: rtl/i2cs_line_events.sv
module i2cs_line_events
    import i2cs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev_o
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev_o.start = scl_q & scl_i & sda_q & ~sda_i;
        ev_o.stop  = scl_q & scl_i & ~sda_q & sda_i;
        ev_o.rise  = ~scl_q & scl_i;
        ev_o.fall  = scl_q & ~scl_i;
    end

endmodule

// File: rtl/i2cs_addr_ctr.sv
module i2cs_addr_ctr
    import i2cs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  ptr_cmd_t          cmd_i,
    input  logic [ADDR_W-1:0] load_val_i,
    output logic [ADDR_W-1:0] ptr_o
);

    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] page_next;

    generate
        if (PAGE_W >= ADDR_W) begin : g_whole
            assign page_next = ptr_q + 1'b1;
        end else begin : g_split
            logic [PAGE_W-1:0] low_next;
            assign low_next  = ptr_q[PAGE_W-1:0] + 1'b1;
            assign page_next = {ptr_q[ADDR_W-1:PAGE_W], low_next};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (cmd_i.load) begin
            ptr_q <= load_val_i;
        end else if (cmd_i.step_seq) begin
            ptr_q <= ptr_q + 1'b1;
        end else if (cmd_i.step_page) begin
            ptr_q <= page_next;
        end
    end

    assign ptr_o = ptr_q;

    // R6 / R7: a read step advances by one, wrapping at the top
    a_r6_seq_step: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.step_seq && !cmd_i.load) |=> (ptr_o == ADDR_W'($past(ptr_o) + 1'b1)));

    // R3: a page step never leaves the page
    a_r3_page_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.step_page && !cmd_i.load && !cmd_i.step_seq)
        |=> (ptr_o[ADDR_W-1:PAGE_W] == $past(ptr_o[ADDR_W-1:PAGE_W])));

endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
    import i2cs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev_i,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [CE_W-1:0]   ce_i,
    input  logic              wr_allow_i,
    input  logic              busy_i,
    input  logic [BYTE_W-1:0] mem_rdata_i,
    output ptr_cmd_t          ptr_cmd_o,
    output logic [ADDR_W-1:0] load_val_o,
    output logic              sda_pull_o,
    output logic              mem_rd_o,
    output logic              ld_strobe_o,
    output logic [BYTE_W-1:0] ld_data_o,
    output logic              tgt_prot_o,
    output logic              commit_o
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    eng_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw_q;
    logic              prot_q;
    logic              have_data;
    logic              first_hi;
    logic              mack_q;
    logic              pull_q;
    logic              strobe_q;
    logic              commit_q;
    logic [BYTE_W-1:0] ld_data_q;
    logic [ADDR_W-1:0] load_val_q;
    ptr_cmd_t          cmd_q;

    logic [1:0]        dec;
    logic [BYTE_W-1:0] rd_byte;
    logic              fetch;

    assign dec     = sel_decode(shreg, ce_i);
    assign rd_byte = prot_q ? '1 : mem_rdata_i;
    assign fetch   = ev_i.fall && !busy_i && !prot_q &&
                     (((state == ST_SEL_ACK) && rw_q) ||
                      ((state == ST_RD_ACK) && mack_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            shreg      <= '0;
            rw_q       <= 1'b0;
            prot_q     <= 1'b0;
            have_data  <= 1'b0;
            first_hi   <= 1'b0;
            mack_q     <= 1'b0;
            pull_q     <= 1'b0;
            strobe_q   <= 1'b0;
            commit_q   <= 1'b0;
            ld_data_q  <= '0;
            load_val_q <= '0;
            cmd_q      <= '0;
        end else begin
            strobe_q <= 1'b0;
            commit_q <= 1'b0;
            cmd_q    <= '0;
            if (busy_i) begin
                state  <= ST_IDLE;
                pull_q <= 1'b0;
            end else if (ev_i.start) begin
                state     <= ST_SEL;
                cnt       <= '0;
                pull_q    <= 1'b0;
                have_data <= 1'b0;
                first_hi  <= 1'b0;
            end else if (ev_i.stop) begin
                if ((state == ST_WR) && first_hi && have_data && (cnt == CNT_ONE)) begin
                    commit_q <= 1'b1;
                end
                state  <= ST_IDLE;
                pull_q <= 1'b0;
            end else begin
                case (state)
                    ST_SEL, ST_ADR, ST_WR: begin
                        if (ev_i.rise) begin
                            shreg    <= {shreg[BYTE_W-2:0], sda_i};
                            cnt      <= cnt + 1'b1;
                            first_hi <= (cnt == '0);
                        end else if (ev_i.fall) begin
                            first_hi <= 1'b0;
                            if (cnt == CNT_FULL) begin
                                cnt <= '0;
                                if (state == ST_SEL) begin
                                    if (dec[1]) begin
                                        pull_q <= 1'b1;
                                        rw_q   <= shreg[0];
                                        prot_q <= dec[0];
                                        state  <= ST_SEL_ACK;
                                    end else begin
                                        state  <= ST_IDLE;
                                    end
                                end else if (state == ST_ADR) begin
                                    pull_q <= 1'b1;
                                    state  <= ST_ADR_ACK;
                                    if (!prot_q) begin
                                        cmd_q.load <= 1'b1;
                                        load_val_q <= ADDR_W'(shreg);
                                    end
                                end else begin
                                    state <= ST_WR_ACK;
                                    if (wr_allow_i) begin
                                        pull_q    <= 1'b1;
                                        have_data <= 1'b1;
                                        if (!prot_q) begin
                                            strobe_q        <= 1'b1;
                                            ld_data_q       <= shreg;
                                            cmd_q.step_page <= 1'b1;
                                        end
                                    end
                                end
                            end
                        end
                    end
                    ST_SEL_ACK: begin
                        if (ev_i.fall) begin
                            cnt <= '0;
                            if (rw_q) begin
                                state          <= ST_RD;
                                shreg          <= rd_byte;
                                pull_q         <= ~rd_byte[BYTE_W-1];
                                cmd_q.step_seq <= !prot_q;
                            end else begin
                                state  <= ST_ADR;
                                pull_q <= 1'b0;
                            end
                        end
                    end
                    ST_ADR_ACK, ST_WR_ACK: begin
                        if (ev_i.fall) begin
                            pull_q <= 1'b0;
                            cnt    <= '0;
                            state  <= ST_WR;
                        end
                    end
                    ST_RD: begin
                        if (ev_i.rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (ev_i.fall) begin
                            if (cnt == CNT_FULL) begin
                                pull_q <= 1'b0;
                                state  <= ST_RD_ACK;
                            end else begin
                                pull_q <= ~shreg[BYTE_W-2];
                                shreg  <= {shreg[BYTE_W-2:0], 1'b1};
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev_i.rise) begin
                            mack_q <= ~sda_i;
                            if (sda_i) begin
                                state <= ST_IDLE;
                            end
                        end else if (ev_i.fall) begin
                            cnt            <= '0;
                            state          <= ST_RD;
                            shreg          <= rd_byte;
                            pull_q         <= ~rd_byte[BYTE_W-1];
                            cmd_q.step_seq <= !prot_q;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ptr_cmd_o   = cmd_q;
    assign load_val_o  = load_val_q;
    assign sda_pull_o  = pull_q;
    assign mem_rd_o    = fetch;
    assign ld_strobe_o = strobe_q;
    assign ld_data_o   = ld_data_q;
    assign tgt_prot_o  = prot_q;
    assign commit_o    = commit_q;

    // R12: the data line is only taken low while the bus clock is low
    a_r12_pull_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> !scl_i);

    // R9: a busy sequencer silences the engine
    a_r9_busy_release: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> !sda_pull_o);

    // R4: commit is a single-cycle pulse
    a_r4_commit_pulse: assert property (@(posedge clk) disable iff (rst)
        commit_o |=> !commit_o);

    // R3: every load strobe coincides with an acknowledge
    a_r3_strobe_acked: assert property (@(posedge clk) disable iff (rst)
        ld_strobe_o |-> sda_pull_o);

    // R11: no page buffer load for the protection target
    a_r11_prot_no_strobe: assert property (@(posedge clk) disable iff (rst)
        ld_strobe_o |-> !tgt_prot_o);

endmodule

// File: rtl/eeprom_cmd_engine.sv
module eeprom_cmd_engine
    import i2cs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [CE_W-1:0]   ce_i,
    input  logic              wr_allow_i,
    input  logic              busy_i,
    input  logic [BYTE_W-1:0] mem_rdata_i,
    output logic              sda_pull_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    output logic              ld_strobe_o,
    output logic [BYTE_W-1:0] ld_data_o,
    output logic              tgt_prot_o,
    output logic              commit_o
);

    line_ev_t          ev;
    ptr_cmd_t          ptr_cmd;
    logic [ADDR_W-1:0] load_val;

    i2cs_line_events u_events (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    i2cs_addr_ctr #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .cmd_i      (ptr_cmd),
        .load_val_i (load_val),
        .ptr_o      (mem_addr_o)
    );

    i2cs_ctrl #(
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ev_i        (ev),
        .scl_i       (scl_i),
        .sda_i       (sda_i),
        .ce_i        (ce_i),
        .wr_allow_i  (wr_allow_i),
        .busy_i      (busy_i),
        .mem_rdata_i (mem_rdata_i),
        .ptr_cmd_o   (ptr_cmd),
        .load_val_o  (load_val),
        .sda_pull_o  (sda_pull_o),
        .mem_rd_o    (mem_rd_o),
        .ld_strobe_o (ld_strobe_o),
        .ld_data_o   (ld_data_o),
        .tgt_prot_o  (tgt_prot_o),
        .commit_o    (commit_o)
    );

endmodule

// File: tb/test_eeprom_cmd_engine.sv
`timescale 1ns/1ps
module test_eeprom_cmd_engine;

    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] ce = 3'b101;
    logic       wr_allow = 1'b1;
    logic       busy = 1'b0;
    logic [7:0] mem_rdata;
    logic       sda_pull;
    logic [7:0] mem_addr;
    logic       mem_rd;
    logic       ld_strobe;
    logic [7:0] ld_data;
    logic       tgt_prot;
    logic       commit;
    logic       sda_bus;

    logic [7:0]  bmem [256];
    logic [15:0] exp_q [$];
    int          checks = 0;
    int          errors = 0;
    int          mon_checks = 0;
    int          mon_errors = 0;
    int          commits = 0;
    logic        last_prot = 1'b0;
    logic        wd_fail = 1'b0;
    logic        pull_prev = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_pull;
    assign mem_rdata = bmem[mem_addr];

    eeprom_cmd_engine i_eeprom_cmd_engine (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .ce_i        (ce),
        .wr_allow_i  (wr_allow),
        .busy_i      (busy),
        .mem_rdata_i (mem_rdata),
        .sda_pull_o  (sda_pull),
        .mem_addr_o  (mem_addr),
        .mem_rd_o    (mem_rd),
        .ld_strobe_o (ld_strobe),
        .ld_data_o   (ld_data),
        .tgt_prot_o  (tgt_prot),
        .commit_o    (commit)
    );

    // reference side: memory image, expected strobes, commit tally, R12 watch
    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) bmem[i] = 8'(i) ^ 8'hA5;
            pull_prev = 1'b0;
        end else begin
            if (ld_strobe) begin
                mon_checks++;
                if (exp_q.size() == 0) begin
                    mon_errors++;
                    $display("FAIL R3: unexpected strobe actual=%h/%h expected=none", mem_addr, ld_data);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    if ({mem_addr, ld_data} != e) begin
                        mon_errors++;
                        $display("FAIL R3: strobe actual=%h expected=%h", {mem_addr, ld_data}, e);
                    end
                end
                bmem[mem_addr] = ld_data;
            end
            if (commit) begin
                commits++;
                last_prot = tgt_prot;
            end
            if (sda_pull && !pull_prev && scl_m) begin
                mon_checks++;
                mon_errors++;
                $display("FAIL R12: pull asserted with scl high actual=1 expected=0");
            end
            pull_prev = sda_pull;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wh(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; wh(H);
        scl_m = 1'b1; wh(H);
        sda_m = 1'b0; wh(H);
        scl_m = 1'b0; wh(H);
    endtask

    task automatic bstop();
        sda_m = 1'b0; wh(H);
        scl_m = 1'b1; wh(H);
        sda_m = 1'b1; wh(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wh(H);
            scl_m = 1'b1; wh(H);
            scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ackbit);
        send_bits(b, 8);
        sda_m = 1'b1; wh(H);
        scl_m = 1'b1; wh(H / 2);
        ackbit = sda_bus;
        wh(H / 2);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wh(H);
            scl_m = 1'b1; wh(H / 2);
            b[i] = sda_bus;
            wh(H / 2);
            scl_m = 1'b0;
        end
        sda_m = mack ? 1'b0 : 1'b1; wh(H);
        scl_m = 1'b1; wh(H);
        scl_m = 1'b0; wh(1);
        sda_m = 1'b1;
    endtask

    localparam logic [7:0] SW = 8'hAA;  // 1010 101 0
    localparam logic [7:0] SR = 8'hAB;  // 1010 101 1
    localparam logic [7:0] PW = 8'h6A;  // 0110 101 0

    task automatic run_all();
        logic       a;
        logic [7:0] d;
        wh(4);
        rst = 1'b0;
        wh(2);
        // R1
        chk("R1 pull", int'(sda_pull), 0);
        chk("R1 strobe/commit", int'({ld_strobe, commit}), 0);
        chk("R1 pointer", int'(mem_addr), 0);

        // R2 mismatching strap bits and type code
        bstart(); send_byte(8'hA6, a); bstop();
        chk("R2 wrong strap nack", int'(a), 1);
        bstart(); send_byte(8'hBA, a); bstop();
        chk("R2 wrong type nack", int'(a), 1);

        // R3 R4 byte write
        bstart(); send_byte(SW, a);
        chk("R2 match ack", int'(a), 0);
        send_byte(8'h20, a); chk("R3 addr ack", int'(a), 0);
        exp_q.push_back({8'h20, 8'h5A});
        send_byte(8'h5A, a); chk("R3 data ack", int'(a), 0);
        bstop(); wh(4);
        chk("R4 commit after byte write", commits, 1);
        chk("R3 strobes consumed", exp_q.size(), 0);

        // R3 page write with in-page wrap
        bstart(); send_byte(SW, a); send_byte(8'h3E, a);
        exp_q.push_back({8'h3E, 8'h11}); send_byte(8'h11, a);
        exp_q.push_back({8'h3F, 8'h22}); send_byte(8'h22, a);
        exp_q.push_back({8'h30, 8'h33}); send_byte(8'h33, a);
        exp_q.push_back({8'h31, 8'h44}); send_byte(8'h44, a);
        chk("R3 last page byte ack", int'(a), 0);
        bstop(); wh(4);
        chk("R4 commit after page write", commits, 2);
        chk("R3 page strobes consumed", exp_q.size(), 0);

        // R5 random read
        bstart(); send_byte(SW, a); send_byte(8'h3E, a);
        bstart(); send_byte(SR, a);
        chk("R5 read select ack", int'(a), 0);
        recv_byte(1'b0, d); bstop(); wh(4);
        chk("R5 random read data", int'(d), 8'h11);
        chk("R4 no commit on dummy write", commits, 2);

        // R6 current address read
        bstart(); send_byte(SR, a); recv_byte(1'b0, d); bstop();
        chk("R6 current read data", int'(d), 8'h22);

        // R7 sequential read with wrap
        bstart(); send_byte(SW, a); send_byte(8'hFE, a);
        bstart(); send_byte(SR, a);
        recv_byte(1'b1, d); chk("R7 seq byte FE", int'(d), 8'h5B);
        recv_byte(1'b1, d); chk("R7 seq byte FF", int'(d), 8'h5A);
        recv_byte(1'b0, d); chk("R7 seq wrap 00", int'(d), 8'hA5);
        bstop();
        bstart(); send_byte(SR, a); recv_byte(1'b0, d);
        chk("R6 current after wrap", int'(d), 8'hA4);

        // R8 standby after NACK (pointer now 02h)
        send_byte(SW, a);
        chk("R8 no ack after nack", int'(a), 1);
        bstop();

        // R9 busy blocks select acknowledge
        busy = 1'b1; wh(2);
        bstart(); send_byte(SW, a); bstop();
        chk("R9 busy nack", int'(a), 1);
        busy = 1'b0; wh(2);
        bstart(); send_byte(SW, a); bstop(); wh(4);
        chk("R9 ack after busy", int'(a), 0);
        chk("R4 no commit after select only", commits, 2);

        // R10 START mid data byte aborts
        bstart(); send_byte(SW, a); send_byte(8'h50, a);
        send_bits(8'hE0, 3);
        bstart(); send_byte(SR, a);
        chk("R10 select after abort ack", int'(a), 0);
        recv_byte(1'b0, d); bstop(); wh(4);
        chk("R10 read after abort", int'(d), 8'hF5);
        chk("R10 no commit", commits, 2);

        // R3 refused data byte
        wr_allow = 1'b0; wh(2);
        bstart(); send_byte(SW, a); send_byte(8'h60, a);
        send_byte(8'h77, a); bstop(); wh(4);
        chk("R3 refused byte nack", int'(a), 1);
        chk("R4 no commit without data", commits, 2);
        wr_allow = 1'b1; wh(2);
        bstart(); send_byte(SR, a); recv_byte(1'b0, d); bstop();
        chk("R3 refused byte left pointer", int'(d), 8'hC5);

        // R4 STOP mid byte
        bstart(); send_byte(SW, a); send_byte(8'h70, a);
        exp_q.push_back({8'h70, 8'h99}); send_byte(8'h99, a);
        send_bits(8'h00, 4); bstop(); wh(4);
        chk("R4 no commit on mid-byte stop", commits, 2);

        // R11 protection target
        bstart(); send_byte(PW, a);
        chk("R11 prot select ack", int'(a), 0);
        send_byte(8'h10, a); send_byte(8'h33, a);
        chk("R11 prot data ack", int'(a), 0);
        bstop(); wh(4);
        chk("R11 prot commit", commits, 3);
        chk("R11 commit target", int'(last_prot), 1);
        chk("R11 no strobe", exp_q.size(), 0);
        bstart(); send_byte(SR, a); recv_byte(1'b0, d); bstop();
        chk("R11 pointer unchanged", int'(d), 8'hD4);
        wh(4);
        chk("R12 line released at end", int'(sda_pull), 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd_fail = 1'b1;
            end
        join_any
        disable fork;
        if (wd_fail) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors + mon_errors, checks + mon_checks);
        $finish;
    end

endmodule